// File: doc/BRIEF.md
# DRAM Bank Timing Guard

This block sits beside the command scheduler of a DRAM controller that issues at most one command per controller clock. It watches activate, write and precharge strobes, each carrying a bank index. For every bank it keeps the row-open state, the time since the last activate and the time since the last write. From these it reports, for each bank, whether a precharge or an activate would be legal now. It also raises a force-close flag for any row that has been open too long.

Four timing limits come from one 32-bit configuration word: write-to-precharge delay, minimum row-open time, maximum row-open time (counted in 1024-clock units) and the length of a rolling window that may hold at most four activates. The word is sampled only while no bank is open, so a bank that is already being timed never sees its limits change. The guard only advises. A command that arrives early is still recorded. An activate to an open bank or a precharge to a closed bank is reported as a protocol error and changes nothing.

Top module: `bank_timing_guard`

## Requirements
- R1: After reset every bank is closed, `pre_ok`, `force_pre` and `proto_err` are 0, `act_ok` is all ones, and the held configuration is 0x0F101B0F. This gives write-to-precharge 15, window 16, maximum open 27 and minimum open 15.
- R2: After an accepted activate to bank b in cycle c, `pre_ok[b]` is 0 until cycle c+N and is 1 from cycle c+N on, where N is the minimum open time. This assumes no other limit blocks it.
- R3: After a write to bank b in cycle c, `pre_ok[b]` is 0 until cycle c+W, where W is the write-to-precharge delay.
- R4: The configuration fields are decoded from these bits: minimum open time from 5:0, maximum open time from 14:8, window length from 21:16, and write-to-precharge delay from 30:24.
- R5: `force_pre[b]` rises once bank b has been open for the maximum open time × 1024 clocks. It stays set until bank b is precharged.
- R6: A maximum open time field of 0 behaves as 1, so the limit is 1024 clocks.
- R7: When the block is built with at least 8 banks, an activate is legal only while fewer than four activates have been accepted, or while the oldest of the last four is at least the window length old. Every bank's `act_ok` is 0 otherwise.
- R8: A window field of 1, or a build with fewer than 8 banks, never blocks activates.
- R9: An activate to an open bank or a precharge to a closed bank drives `proto_err` high in the same cycle. The command changes neither the bank's state nor its timers.
- R10: The configuration word is loaded only at clock edges where no bank is open. Changes made while any bank is open are held off until all banks are closed.
- R11: `act_ok[b]` is 0 whenever bank b is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Packed timing configuration |
| act_i | input | 1 | Activate strobe |
| wr_i | input | 1 | Write strobe |
| pre_i | input | 1 | Precharge strobe |
| cmd_bank | input | 3 | Bank addressed by the strobe |
| pre_ok | output | 8 | Precharge legal, per bank |
| act_ok | output | 8 | Activate legal, per bank |
| force_pre | output | 8 | Row open too long, per bank |
| bank_open | output | 8 | Row-open state, per bank |
| proto_err | output | 1 | Illegal state transition this cycle |

## Verification
The minimum-open limit and the write-to-precharge limit both gate the same `pre_ok` bit, and the later of the two decides. The bench provokes this by writing to a bank just as its minimum-open time runs out. It then checks that `pre_ok` drops at once and comes back exactly W cycles after the write. Two more functions share a cycle in other tests. A repeated activate raises the error pulse while the activate timer keeps running, and the bench judges this by checking that `pre_ok` still rises N cycles after the first activate. A configuration change made while a row is open must not shorten that row's limits.

// File: rtl/bkg_pkg.sv
package bkg_pkg;

   localparam int CFG_W        = 32;
   localparam int RMIN_LSB     = 0;
   localparam int RMIN_W       = 6;
   localparam int RMAX_LSB     = 8;
   localparam int RMAX_W       = 7;
   localparam int WIN_LSB      = 16;
   localparam int WIN_W        = 6;
   localparam int W2P_LSB      = 24;
   localparam int W2P_W        = 7;
   localparam int RMAX_SHIFT   = 10;
   localparam int ACT_LIMIT    = 4;
   localparam logic [CFG_W-1:0] CFG_RESET = 32'h0F10_1B0F;

   typedef struct packed {
      logic [W2P_W-1:0]  w2p;
      logic [WIN_W-1:0]  win;
      logic [RMAX_W-1:0] rmax;
      logic [RMIN_W-1:0] rmin;
   } timing_t;

   // Field extraction; a zero maximum open time is promoted to one unit.
   function automatic timing_t unpack_timing(input logic [CFG_W-1:0] w);
      timing_t t;
      t.w2p  = w[W2P_LSB  +: W2P_W];
      t.win  = w[WIN_LSB  +: WIN_W];
      t.rmax = w[RMAX_LSB +: RMAX_W];
      t.rmin = w[RMIN_LSB +: RMIN_W];
      if (t.rmax == '0) t.rmax = RMAX_W'(1);
      return t;
   endfunction

endpackage

// File: rtl/bkg_cfg_hold.sv
module bkg_cfg_hold
   import bkg_pkg::*;
#(
   parameter logic [CFG_W-1:0] RESET_WORD = CFG_RESET
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             all_idle,
   input  logic [CFG_W-1:0] cfg_word,
   output timing_t          tim
);

   logic [CFG_W-1:0] word_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        word_q <= RESET_WORD;
      else if (all_idle) word_q <= cfg_word;
   end

   assign tim = unpack_timing(word_q);

   // R10: held word cannot move while any row is open
   p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !all_idle |=> $stable(word_q));

endmodule

// File: rtl/bkg_act_window.sv
module bkg_act_window
   import bkg_pkg::*;
#(
   parameter bit ENABLE = 1'b1,
   parameter int DEPTH  = ACT_LIMIT,
   parameter int AGE_W  = WIN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_take,
   input  logic [WIN_W-1:0] win_len,
   output logic             win_ok
);

   if (AGE_W < WIN_W) begin : g_bad_age
      $error("bkg_act_window: AGE_W narrower than window field");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("bkg_act_window: DEPTH must be positive");
   end

   localparam logic [AGE_W-1:0] AGE_MAX = '1;

   if (ENABLE) begin : g_window
      logic [AGE_W-1:0] age_q [DEPTH];
      logic [DEPTH-1:0] vld_q;

      function automatic logic [AGE_W-1:0] bump(input logic [AGE_W-1:0] a);
         return (a == AGE_MAX) ? a : a + AGE_W'(1);
      endfunction

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= '0;
            for (int k = 0; k < DEPTH; k++) age_q[k] <= '0;
         end else if (act_take) begin
            vld_q    <= {vld_q[DEPTH-2:0], 1'b1};
            age_q[0] <= AGE_W'(1);
            for (int k = 1; k < DEPTH; k++) age_q[k] <= bump(age_q[k-1]);
         end else begin
            for (int k = 0; k < DEPTH; k++) age_q[k] <= bump(age_q[k]);
         end
      end

      assign win_ok = !vld_q[DEPTH-1] ||
                      (age_q[DEPTH-1] >= AGE_W'(win_len));

      // R7: the oldest entry only ages while the history is full and idle
      p_window_ages_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !act_take && vld_q[DEPTH-1] && (age_q[DEPTH-1] != AGE_MAX)
         |=> age_q[DEPTH-1] == $past(age_q[DEPTH-1]) + AGE_W'(1));
   end else begin : g_no_window
      assign win_ok = 1'b1;
   end

endmodule

// File: rtl/bkg_bank_track.sv
module bkg_bank_track
   import bkg_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    act_hit,
   input  logic    wr_hit,
   input  logic    pre_hit,
   input  timing_t tim,
   output logic    open_o,
   output logic    pre_ok_o,
   output logic    force_o,
   output logic    err_o
);

   localparam int RAS_W = RMAX_W + RMAX_SHIFT;
   localparam logic [RAS_W-1:0] RAS_MAX = '1;
   localparam logic [W2P_W-1:0] WR_MAX  = '1;

   logic             open_q;
   logic [RAS_W-1:0] ras_q;
   logic [W2P_W-1:0] wr_q;
   logic             act_go, pre_go;
   logic [RAS_W-1:0] ras_lim, ras_floor;

   assign act_go = act_hit && !open_q;
   assign pre_go = pre_hit &&  open_q;
   assign err_o  = (act_hit && open_q) || (pre_hit && !open_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         ras_q  <= '0;
         wr_q   <= WR_MAX;
      end else begin
         if (act_go)      open_q <= 1'b1;
         else if (pre_go) open_q <= 1'b0;

         if (act_go)                          ras_q <= RAS_W'(1);
         else if (open_q && ras_q != RAS_MAX) ras_q <= ras_q + RAS_W'(1);

         if (wr_hit)              wr_q <= W2P_W'(1);
         else if (wr_q != WR_MAX) wr_q <= wr_q + W2P_W'(1);
      end
   end

   assign ras_lim   = {tim.rmax, {RMAX_SHIFT{1'b0}}};
   assign ras_floor = {{(RAS_W-RMIN_W){1'b0}}, tim.rmin};

   assign open_o   = open_q;
   assign pre_ok_o = open_q && (ras_q >= ras_floor) && (wr_q >= tim.w2p);
   assign force_o  = open_q && (ras_q >= ras_lim);

   // R5: once raised, force stays until this bank is precharged
   p_force_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      force_o && !pre_go |=> force_o);

   // R3: a write blocks precharge on the following cycle
   p_wr_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit && (tim.w2p > W2P_W'(1)) |=> !pre_ok_o);

endmodule

// File: rtl/bank_timing_guard.sv
module bank_timing_guard
   import bkg_pkg::*;
#(
   parameter int NUM_BANKS     = 8,
   parameter int WIN_MIN_BANKS = 8,
   parameter int BANK_W        = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CFG_W-1:0]     cfg_word,
   input  logic                 act_i,
   input  logic                 wr_i,
   input  logic                 pre_i,
   input  logic [BANK_W-1:0]    cmd_bank,
   output logic [NUM_BANKS-1:0] pre_ok,
   output logic [NUM_BANKS-1:0] act_ok,
   output logic [NUM_BANKS-1:0] force_pre,
   output logic [NUM_BANKS-1:0] bank_open,
   output logic                 proto_err
);

   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("bank_timing_guard: NUM_BANKS must be at least 2");
   end
   if ((1 << BANK_W) != NUM_BANKS) begin : g_bad_pow2
      $error("bank_timing_guard: NUM_BANKS must be a power of two");
   end

   localparam bit WIN_ON = (NUM_BANKS >= WIN_MIN_BANKS);

   timing_t                tim;
   logic [NUM_BANKS-1:0]   err_v;
   logic                   win_ok;
   logic                   act_take;

   bkg_cfg_hold u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .all_idle (~|bank_open),
      .cfg_word (cfg_word),
      .tim      (tim)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel;
      assign sel = (cmd_bank == BANK_W'(b));

      bkg_bank_track u_trk (
         .clk      (clk),
         .rst_n    (rst_n),
         .act_hit  (act_i && sel),
         .wr_hit   (wr_i  && sel),
         .pre_hit  (pre_i && sel),
         .tim      (tim),
         .open_o   (bank_open[b]),
         .pre_ok_o (pre_ok[b]),
         .force_o  (force_pre[b]),
         .err_o    (err_v[b])
      );
   end

   assign act_take = act_i && !bank_open[cmd_bank];

   bkg_act_window #(.ENABLE(WIN_ON)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_take (act_take),
      .win_len  (tim.win),
      .win_ok   (win_ok)
   );

   assign act_ok    = ~bank_open & {NUM_BANKS{win_ok}};
   assign proto_err = |err_v;

   // R9: a rejected command leaves every row state as it was
   p_err_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> $stable(bank_open));

   // R9: the scheduler sends at most one command per clock
   p_one_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({act_i, wr_i, pre_i}));

endmodule

// File: tb/sim_bank_timing_guard.sv
module sim_bank_timing_guard;

   localparam int NB = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [31:0]   cfg_word;
   logic          act_i, wr_i, pre_i;
   logic [2:0]    cmd_bank;
   logic [NB-1:0] pre_ok, act_ok, force_pre, bank_open;
   logic          proto_err;

   int errors = 0;
   int checks = 0;
   logic last_err;

   always #10 clk = ~clk;   // 50 MHz

   bank_timing_guard u0 (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
      .act_i(act_i), .wr_i(wr_i), .pre_i(pre_i), .cmd_bank(cmd_bank),
      .pre_ok(pre_ok), .act_ok(act_ok), .force_pre(force_pre),
      .bank_open(bank_open), .proto_err(proto_err)
   );

   // op: 0 idle, 1 activate, 2 write, 3 precharge
   typedef struct packed {
      logic [1:0] op;
      logic [2:0] bank;
      logic [7:0] gap;
      logic       e_err;
      logic       e_pre;
      logic       e_act;
   } vec_t;

   // Default timing after reset: rmin 15, w2p 15, window 16
   localparam vec_t VECS [9] = '{
      '{2'd1, 3'd0, 8'd13, 1'b0, 1'b0, 1'b0},  // R2 open time 14
      '{2'd0, 3'd0, 8'd0,  1'b0, 1'b1, 1'b0},  // R2 open time 15
      '{2'd2, 3'd0, 8'd13, 1'b0, 1'b0, 1'b0},  // R3 write age 14
      '{2'd0, 3'd0, 8'd0,  1'b0, 1'b1, 1'b0},  // R3 write age 15
      '{2'd3, 3'd0, 8'd0,  1'b0, 1'b0, 1'b1},  // R11 closed again
      '{2'd3, 3'd0, 8'd0,  1'b1, 1'b0, 1'b1},  // R9 precharge closed
      '{2'd1, 3'd1, 8'd0,  1'b0, 1'b0, 1'b0},  // R11 opened
      '{2'd1, 3'd1, 8'd0,  1'b1, 1'b0, 1'b0},  // R9 activate open
      '{2'd0, 3'd1, 8'd12, 1'b0, 1'b1, 1'b0}   // R9 timer kept: 15
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the capturing edge
   task automatic issue(input int op, input int bank);
      cmd_bank = 3'(bank);
      act_i = (op == 1);
      wr_i  = (op == 2);
      pre_i = (op == 3);
      #1 last_err = proto_err;
      @(posedge clk);
      @(negedge clk);
      act_i = 1'b0; wr_i = 1'b0; pre_i = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cfg_word = 32'h0F10_1B0F;
      act_i = 1'b0; wr_i = 1'b0; pre_i = 1'b0; cmd_bank = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      do_reset();
      check("R1", "bank_open", 32'(bank_open), 32'h0);
      check("R1", "pre_ok",    32'(pre_ok),    32'h0);
      check("R1", "act_ok",    32'(act_ok),    32'hFF);
      check("R1", "force_pre", 32'(force_pre), 32'h0);
      check("R1", "proto_err", 32'(proto_err), 32'h0);

      // vector table
      for (int i = 0; i < 9; i++) begin
         issue(int'(VECS[i].op), int'(VECS[i].bank));
         repeat (int'(VECS[i].gap)) @(negedge clk);
         check("R9", $sformatf("vec%0d err", i), 32'(last_err), 32'(VECS[i].e_err));
         check("R2", $sformatf("vec%0d pre_ok", i),
               32'(pre_ok[VECS[i].bank]), 32'(VECS[i].e_pre));
         check("R11", $sformatf("vec%0d act_ok", i),
               32'(act_ok[VECS[i].bank]), 32'(VECS[i].e_act));
      end

      // R7: four activates fill the window of 16
      do_reset();
      for (int b = 0; b < 4; b++) issue(1, b);
      repeat (11) @(negedge clk);
      check("R7", "act_ok b4 age 15", 32'(act_ok[4]), 32'h0);
      check("R7", "act_ok b5 age 15", 32'(act_ok[5]), 32'h0);
      @(negedge clk);
      check("R7", "act_ok b4 age 16", 32'(act_ok[4]), 32'h1);
      issue(1, 4);
      check("R7", "act_ok b5 after slide", 32'(act_ok[5]), 32'h1);

      // R10: config change held while a row is open
      do_reset();
      issue(1, 0);
      cfg_word = 32'h0201_0103;   // R4: w2p 2, win 1, rmax 1, rmin 3
      issue(1, 1);
      repeat (2) @(negedge clk);
      check("R10", "old rmin kept", 32'(pre_ok[1]), 32'h0);
      issue(3, 0);
      issue(3, 1);
      issue(1, 2);
      @(negedge clk);
      check("R2", "new rmin age 2", 32'(pre_ok[2]), 32'h0);
      @(negedge clk);
      check("R10", "new rmin age 3", 32'(pre_ok[2]), 32'h1);
      issue(2, 2);
      check("R3", "write age 1", 32'(pre_ok[2]), 32'h0);
      @(negedge clk);
      check("R3", "write age 2", 32'(pre_ok[2]), 32'h1);

      // R8: window field 1 never blocks
      for (int b = 3; b < 7; b++) issue(1, b);
      check("R8", "act_ok b7", 32'(act_ok[7]), 32'h1);

      // R5: forced close after 1024 clocks
      issue(1, 7);
      repeat (1022) @(negedge clk);
      check("R5", "force at 1023", 32'(force_pre[7]), 32'h0);
      @(negedge clk);
      check("R5", "force at 1024", 32'(force_pre[7]), 32'h1);
      repeat (5) @(negedge clk);
      check("R5", "force held", 32'(force_pre[7]), 32'h1);
      issue(3, 7);
      check("R5", "force cleared", 32'(force_pre[7]), 32'h0);

      // R6: zero maximum field acts as one unit
      cfg_word = 32'h0201_0003;
      for (int b = 2; b < 7; b++) issue(3, b);
      check("R10", "all closed", 32'(bank_open), 32'h0);
      issue(1, 0);
      repeat (1022) @(negedge clk);
      check("R6", "force at 1023", 32'(force_pre[0]), 32'h0);
      @(negedge clk);
      check("R6", "force at 1024", 32'(force_pre[0]), 32'h1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule